// File: doc/BRIEF.md
# Event-Paced VGA Sync Generator

This block produces the horizontal and vertical synchronisation signals for a 640x480 display. It advances on a pixel-clock enable that is one system-clock cycle wide and repeats at the pixel rate, typically 25 MHz. A horizontal phase counter times each line. On the enabled cycle that closes the back porch, it emits a one-cycle end-of-line event.

A second phase counter handles vertical timing. It is paced only by those end-of-line events, so it counts lines and never pixels, and it shapes the vertical sync from that count. A small arming stage sits between the vertical engine and a downstream pixel engine. When a line is about to become vertically active, the arming stage issues a one-cycle line-start pulse on the first pixel clock of that line, so colour output and horizontal active time begin together. On line 0 a frame-start pulse accompanies the line-start pulse.

No data stream crosses this block, so there is no valid/ready interface. All pins are plain control signals. Every phase length is a parameter, and the defaults give the 800-clock line and the 525-line frame.

Top module: `vgs_sync_top`

## Requirements
- R1: A line lasts H_ACT+H_FP+H_SYNC+H_BP enabled clocks (defaults 640, 16, 96, 48, total 800). The phases run in the order active, front porch, sync, back porch. `hsync` is low exactly during the H_SYNC enabled clocks that follow active time and the front porch, and high at all other times.
- R2: When `pix_en` is low, no output changes state. Both engines advance only on clock edges where `pix_en` is high.
- R3: `line_end` is high for exactly one clock, on the enabled clock that is the last position of the back porch, and never on any other clock.
- R4: The frame lasts V_ACT+V_FP+V_SYNC+V_BP lines (defaults 480, 10, 2, 33). Each line is counted by one `line_end` event. `vsync` is low exactly during the V_SYNC lines that follow the active and front-porch lines, and it changes only on the clock after a `line_end`.
- R5: `line_start` pulses for one clock on the first enabled clock (horizontal position 0) of every vertically active line, and never in vertical blanking.
- R6: `frame_start` pulses together with the `line_start` of line 0, and at no other time.
- R7: During synchronous active-low reset, and on release, both engines sit at the start of active time. `hsync` and `vsync` are high, and `line_end` is low. With `pix_en` low, `line_start` and `frame_start` are also low.
- R8: Between two consecutive `frame_start` pulses there are exactly (line length) x (frame length) enabled clocks. The default is 420000.
- R9: A reset asserted mid-frame returns both engines to the start of active time. The next enabled clock gives a `line_start` together with a `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | input | 1 | Pixel-clock enable, one cycle per pixel |
| hsync | output | 1 | Horizontal sync, low during the horizontal sync pulse |
| vsync | output | 1 | Vertical sync, low during the vertical sync lines |
| line_end | output | 1 | One-cycle event at the end of the horizontal back porch |
| line_start | output | 1 | One-cycle event at the first pixel of a vertically active line |
| frame_start | output | 1 | One-cycle event at the first pixel of line 0 |

## Verification
The hardest state to reach is the wrap of the vertical engine. It needs a whole frame of enabled clocks, and its pulses must line up exactly with the line-end and line-start pulses at the turn of the frame. With default timing a frame takes 420000 enables. The bench therefore elaborates the block with shortened phase lengths, so several frame wraps fit in the run. It drives `pix_en` with random gaps, long continuous bursts and long idle stretches, so wraps fall under every enable pattern. A reset in mid-frame covers the return to line 0.

// File: rtl/vgs_pkg.sv
package vgs_pkg;

  typedef enum logic [1:0] {
    PH_ACTIVE = 2'd0,
    PH_FRONT  = 2'd1,
    PH_SYNC   = 2'd2,
    PH_BACK   = 2'd3
  } vgs_phase_e;

  // Width that holds positions 0 .. total-1 (at least one bit).
  function automatic int unsigned pos_width(input int unsigned total);
    return (total < 2) ? 1 : $clog2(total);
  endfunction

endpackage

// File: rtl/vgs_phase_ctr.sv
module vgs_phase_ctr
  import vgs_pkg::*;
#(
  parameter int unsigned ACT  = 640,
  parameter int unsigned FP   = 16,
  parameter int unsigned SYNC = 96,
  parameter int unsigned BP   = 48,
  localparam int unsigned TOTAL = ACT + FP + SYNC + BP,
  localparam int unsigned W     = pos_width(TOTAL)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] pos,
  output vgs_phase_e   phase,
  output logic         wrap,
  output logic         enter_active,
  output logic         sync_n
);

  localparam logic [W-1:0] LAST     = W'(TOTAL - 1);
  localparam logic [W-1:0] FP_START = W'(ACT);
  localparam logic [W-1:0] SY_START = W'(ACT + FP);
  localparam logic [W-1:0] BP_START = W'(ACT + FP + SYNC);

  logic [W-1:0] pos_q;
  logic [W-1:0] pos_next;

  always_comb begin
    pos_next = (pos_q == LAST) ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    pos_q <= '0;
    else if (step) pos_q <= pos_next;
  end

  always_comb begin
    if (pos_q < FP_START)      phase = PH_ACTIVE;
    else if (pos_q < SY_START) phase = PH_FRONT;
    else if (pos_q < BP_START) phase = PH_SYNC;
    else                       phase = PH_BACK;
  end

  assign pos          = pos_q;
  assign wrap         = step && (pos_q == LAST);
  assign enter_active = step && (pos_next < FP_START);
  assign sync_n       = (phase != PH_SYNC);

endmodule

// File: rtl/vgs_line_arm.sv
module vgs_line_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_en,
  input  logic arm_line,
  input  logic arm_frame,
  output logic line_start,
  output logic frame_start
);

  // Reset leaves line 0 active, so both flags start armed.
  logic line_armed_q;
  logic frame_armed_q;

  assign line_start  = line_armed_q && pix_en;
  assign frame_start = line_start && frame_armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_armed_q  <= 1'b1;
      frame_armed_q <= 1'b1;
    end else begin
      if (arm_line)        line_armed_q <= 1'b1;
      else if (line_start) line_armed_q <= 1'b0;
      if (arm_frame)       frame_armed_q <= 1'b1;
      else if (line_start) frame_armed_q <= 1'b0;
    end
  end

endmodule

// File: rtl/vgs_sync_top.sv
module vgs_sync_top
  import vgs_pkg::*;
#(
  parameter int unsigned H_ACT  = 640,
  parameter int unsigned H_FP   = 16,
  parameter int unsigned H_SYNC = 96,
  parameter int unsigned H_BP   = 48,
  parameter int unsigned V_ACT  = 480,
  parameter int unsigned V_FP   = 10,
  parameter int unsigned V_SYNC = 2,
  parameter int unsigned V_BP   = 33,
  localparam int unsigned HW = pos_width(H_ACT + H_FP + H_SYNC + H_BP),
  localparam int unsigned VW = pos_width(V_ACT + V_FP + V_SYNC + V_BP)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_en,
  output logic hsync,
  output logic vsync,
  output logic line_end,
  output logic line_start,
  output logic frame_start
);

  logic [HW-1:0] h_pos;
  vgs_phase_e    h_phase;
  logic          h_wrap;
  logic          h_enter_unused;
  logic          h_sync_n;

  logic [VW-1:0] v_pos;
  vgs_phase_e    v_phase;
  logic          v_wrap;
  logic          v_enter_active;
  logic          v_sync_n;

  vgs_phase_ctr #(.ACT(H_ACT), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP)) i_hctr (
    .clk          (clk),
    .rst_n        (rst_n),
    .step         (pix_en),
    .pos          (h_pos),
    .phase        (h_phase),
    .wrap         (h_wrap),
    .enter_active (h_enter_unused),
    .sync_n       (h_sync_n)
  );

  // Vertical engine is paced solely by the end-of-line event.
  vgs_phase_ctr #(.ACT(V_ACT), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP)) i_vctr (
    .clk          (clk),
    .rst_n        (rst_n),
    .step         (h_wrap),
    .pos          (v_pos),
    .phase        (v_phase),
    .wrap         (v_wrap),
    .enter_active (v_enter_active),
    .sync_n       (v_sync_n)
  );

  vgs_line_arm i_arm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_en      (pix_en),
    .arm_line    (v_enter_active),
    .arm_frame   (v_wrap),
    .line_start  (line_start),
    .frame_start (frame_start)
  );

  assign hsync    = h_sync_n;
  assign vsync    = v_sync_n;
  assign line_end = h_wrap;

endmodule

// File: rtl/vgs_sync_checker.sv
module vgs_sync_checker (
  input logic clk,
  input logic rst_n,
  input logic pix_en,
  input logic hsync,
  input logic vsync,
  input logic line_end,
  input logic line_start,
  input logic frame_start
);

  // R2: hsync moves only across an enabled edge
  a_r2_hsync_paced: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hsync) |-> $past(pix_en));

  // R3: the end-of-line event only appears on an enabled clock
  a_r3_line_end_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |-> pix_en);

  // R3: line_end is one clock wide
  a_r3_line_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> !line_end);

  // R4: vsync changes only on the clock after a line_end
  a_r4_vsync_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync) |-> $past(line_end));

  // R5: line_start rides an enabled clock and never overlaps line_end
  a_r5_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> (pix_en && !line_end));

  // R5: line_start is one clock wide
  a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);

  // R6: frame_start always accompanies a line_start
  a_r6_frame_with_line: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_start);

  // R7: during reset line_end stays low
  a_r7_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !line_end);

endmodule

bind vgs_sync_top vgs_sync_checker i_vgs_chk (.*);

// File: tb/test_vgs_sync_top.sv
module test_vgs_sync_top;

  localparam int HA = 20, HF = 3, HS = 5, HB = 4;
  localparam int VA = 12, VF = 2, VS = 2, VB = 3;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_en = 1'b0;
  logic hsync, vsync, line_end, line_start, frame_start;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // bench-side position model
  int mh = 0, mv = 0;
  int pe_count = 0;
  bit seen_frame = 1'b0;
  int frames = 0;

  always #5 clk = ~clk;

  vgs_sync_top #(
    .H_ACT(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACT(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) i_vgs_sync_top (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .hsync(hsync), .vsync(vsync), .line_end(line_end),
    .line_start(line_start), .frame_start(frame_start)
  );

  function automatic bit exp_hsync(int h);
    return !((h >= HA + HF) && (h < HA + HF + HS));
  endfunction

  function automatic bit exp_vsync(int v);
    return !((v >= VA + VF) && (v < VA + VF + VS));
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %b expected %b (h=%0d v=%0d)",
               req, cyc, act, exp, mh, mv);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one clock with the given enable, check outputs, advance the model.
  task automatic step(bit pe);
    bit fs;
    @(negedge clk);
    pix_en = pe;
    #1;
    fs = pe && (mh == 0) && (mv == 0);
    chk("R1 hsync", hsync, exp_hsync(mh));
    chk("R4 vsync", vsync, exp_vsync(mv));
    chk("R3 line_end", line_end, pe && (mh == HT - 1));
    chk("R5 line_start", line_start, pe && (mh == 0) && (mv < VA));
    chk("R6 frame_start", frame_start, fs);
    if (fs) begin
      if (seen_frame) chk_int("R8 frame length", pe_count, HT * VT);
      seen_frame = 1'b1;
      pe_count = 0;
      frames++;
    end
    if (pe) begin
      pe_count++;
      if (mh == HT - 1) begin
        mh = 0;
        mv = (mv == VT - 1) ? 0 : mv + 1;
      end else begin
        mh++;
      end
    end
  endtask

  task automatic do_reset(int n);
    @(negedge clk);
    rst_n = 1'b0;
    pix_en = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      // R7: reset state
      chk("R7 hsync in reset", hsync, 1'b1);
      chk("R7 vsync in reset", vsync, 1'b1);
      chk("R7 line_end in reset", line_end, 1'b0);
      chk("R7 line_start in reset", line_start, 1'b0);
      chk("R7 frame_start in reset", frame_start, 1'b0);
    end
    rst_n = 1'b1;
    mh = 0; mv = 0; pe_count = 0; seen_frame = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit dummy;
    int fr0;
    dummy = 1'(process::self() != null);
    void'($urandom(32'd20240611));
    do_reset(3);

    // R9/R5: first enabled clock after reset starts line 0 and a frame
    step(1'b0);
    step(1'b1);

    // random enable pattern across several frame wraps
    for (int i = 0; i < 4000; i++) step(1'($urandom_range(0, 99) < 55));

    // R2: long idle stretch, outputs must hold
    for (int i = 0; i < 60; i++) step(1'b0);

    // continuous enable burst across a full frame
    for (int i = 0; i < HT * VT + 50; i++) step(1'b1);

    // R9: reset in the middle of a frame
    for (int i = 0; i < 137; i++) step(1'b1);
    do_reset(2);
    fr0 = frames;
    step(1'b1);
    chk_int("R9 frame restarts after reset", frames - fr0, 1);

    // sparse enables, one in four, like a 25 MHz enable
    for (int i = 0; i < 5200; i++) step((i % 4) == 0);

    // R8: at least two wraps were measured
    checks++;
    if (frames < 4) begin
      errors++;
      $display("FAIL R8 too few frames seen: got %0d expected >= 4", frames);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule